// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the device side of a byte-wide serial memory reached over SPI in mode 0. Instruction, address and data bytes are received most significant bit first while CS_n is low. An 8-bit instruction is decoded and the block then does one of six things: sets or clears a write enable latch, returns a status byte, programs the protection fields of the status register, reads bytes from the array or writes a byte to it. The array is a small on-chip store that stands in for the nonvolatile cells.

A status write or a byte write is committed only when CS_n rises after a whole number of bytes. The commit starts an internal write cycle that lasts a parameterised number of system clocks. While that cycle runs the status register reads as all ones, and every instruction other than a status read is dropped. SCK, CS_n and MOSI are synchronised to the system clock and sampled there, so the system clock has to run several times faster than SCK.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the status byte reads 0x00, the write enable latch is clear and MISO is 0.
- R2: An instruction byte is valid only when bits 7..4 are zero. Bit 3 is ignored, and bits 2..0 select the operation: 110 enable writes, 100 disable writes, 101 read status, 001 write status, 011 read array, 010 write array. The codes 000 and 111, and any byte whose high nibble is nonzero, have no effect.
- R3: The enable-writes instruction sets the WEN flag (status bit 1). A write-array or write-status instruction issued while WEN is clear changes nothing and starts no write cycle.
- R4: The disable-writes instruction clears WEN whatever the level on wp_n.
- R5: Read-array takes a 16-bit address, MSB first. The low MEM_AW bits index the array and bit 15 is ignored. Bytes then stream out from successive addresses, wrapping at the end of the array, until CS_n rises.
- R6: Write-array stores its first data byte, and write-status stores its data byte. Either one is committed only if CS_n rises with the bit count on a byte boundary. A frame that ends partway through a byte commits nothing and leaves WEN as it was.
- R7: A commit holds the device busy for WRITE_CYCLES system clocks. While busy, a status read returns 0xFF. WEN is cleared when the cycle ends.
- R8: While busy, every instruction except read-status is ignored. A read-array issued then returns only zeros on MISO.
- R9: When idle, the status byte is {WPEN, 0, 0, 0, BP1, BP0, WEN, RDY=0}. Write-status stores data bits 7, 3 and 2 into WPEN, BP1 and BP0, and bits 6..4 read back as 0.
- R10: A write-status frame is not committed when WPEN is 1 and wp_n is low. It starts no write cycle and WEN stays set.
- R11: MISO is driven only during the data phase of a read-status or read-array frame. Each byte's MSB appears after the SCK falling edge that ends the previous byte. MISO is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SPI pins are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | Active-low chip select; frames its transaction |
| mosi | input | 1 | Serial data into the device, MSB first |
| wp_n | input | 1 | Active-low write-protect level for status writes |
| miso | output | 1 | Serial data out of the device; 0 when not driven |

## Verification
The bound checker watches four things on every cycle. MISO stays low once CS_n has been high for several clocks. A write cycle can start only with WEN set. No write cycle lasts longer than WRITE_CYCLES clocks, and WEN is clear as the cycle ends. Neither a new WEN nor an array write can appear while busy. The bench scenarios cover the rest: opcode aliasing through bit 3, address folding and read wrap, rejection of partial frames, the 0xFF status while busy, and protection of the status register by wp_n. These can only be seen by driving whole SPI frames and comparing the bytes read back.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    // Operation selected by instruction bits 2..0
    typedef enum logic [2:0] {
        OP_NOP0  = 3'b000,
        OP_WRSR  = 3'b001,
        OP_WRITE = 3'b010,
        OP_READ  = 3'b011,
        OP_WRDI  = 3'b100,
        OP_RDSR  = 3'b101,
        OP_WREN  = 3'b110,
        OP_NOP7  = 3'b111
    } op_e;

    // Frame phase
    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_RD_DATA,
        PH_WR_DATA,
        PH_ST_READ,
        PH_ST_WRITE,
        PH_DISCARD
    } phase_e;

    // Stored protection fields of the status register
    typedef struct packed {
        logic wpen;
        logic bp1;
        logic bp0;
    } prot_t;

    function automatic op_e decode_op(input logic [3:0] hi_nib, input logic [2:0] code);
        if (hi_nib != 4'h0) return OP_NOP0;
        return op_e'(code);
    endfunction

    function automatic logic [7:0] status_byte(input prot_t p, input logic wen, input logic busy);
        if (busy) return 8'hFF;
        return {p.wpen, 3'b000, p.bp1, p.bp0, wen, 1'b0};
    endfunction

endpackage

// File: rtl/spi_eeprom_pin_sync.sv
module spi_eeprom_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_low,
    output logic mosi_s
);
    // per stage: {sck, cs_n, mosi}
    logic [2:0] stg [STAGES];
    logic       sck_d;
    logic       cs_d;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= 3'b010;
        else     stg[0] <= {sck_i, cs_n_i, mosi_i};
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= 3'b010;
            else     stg[g] <= stg[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= stg[STAGES-1][2];
            cs_d  <= stg[STAGES-1][1];
        end
    end

    assign sck_rise = stg[STAGES-1][2] & ~sck_d;
    assign sck_fall = ~stg[STAGES-1][2] & sck_d;
    assign cs_fall  = ~stg[STAGES-1][1] & cs_d;
    assign cs_rise  = stg[STAGES-1][1] & ~cs_d;
    assign cs_low   = ~stg[STAGES-1][1];
    assign mosi_s   = stg[STAGES-1][0];
endmodule

// File: rtl/spi_eeprom_busy_timer.sv
module spi_eeprom_busy_timer #(
    parameter int unsigned CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = busy && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt  <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/spi_eeprom_cell_array.sv
module spi_eeprom_cell_array #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
    import spi_eeprom_pkg::*;
#(
    parameter int unsigned MEM_AW       = 8,
    parameter int unsigned WRITE_CYCLES = 64,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    input  logic wp_n,
    output logic miso
);
    logic sck_rise, sck_fall, cs_fall, cs_rise, cs_low, mosi_s;

    spi_eeprom_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise),
        .cs_low(cs_low), .mosi_s(mosi_s)
    );

    phase_e            phase;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_sr;
    logic [7:0]        rx_byte;
    logic [MEM_AW-1:0] addr;
    logic [MEM_AW-1:0] addr_next;
    logic [MEM_AW-1:0] rd_ptr;
    logic [MEM_AW-1:0] mem_raddr;
    logic [7:0]        mem_rdata;
    logic [7:0]        tx_next;
    logic [7:0]        tx_sr;
    logic              wel;
    logic              is_read;
    logic              pend_valid;
    logic [7:0]        pend_data;
    prot_t             prot;
    logic              busy;
    logic              tmr_done;
    logic              commit_ok;
    logic              mem_we;
    logic              sr_commit;
    logic [7:0]        stat_now;
    op_e               op_dec;

    assign rx_byte   = {rx_sr, mosi_s};
    assign addr_next = (addr << 8) | MEM_AW'(rx_byte);
    assign op_dec    = decode_op(rx_byte[7:4], rx_byte[2:0]);
    assign stat_now  = status_byte(prot, wel, busy);
    assign mem_raddr = (phase == PH_ADDR_LO) ? addr_next : rd_ptr;

    // commit only on a byte boundary with the latch still set
    assign commit_ok = cs_rise && pend_valid && (bit_cnt == 3'd0) && wel && !busy;
    assign mem_we    = commit_ok && (phase == PH_WR_DATA);
    assign sr_commit = commit_ok && (phase == PH_ST_WRITE) && !(prot.wpen && !wp_n);

    spi_eeprom_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst(rst),
        .start(mem_we || sr_commit),
        .busy(busy), .done(tmr_done)
    );

    spi_eeprom_cell_array #(.AW(MEM_AW)) u_cells (
        .clk(clk), .we(mem_we),
        .waddr(addr), .wdata(pend_data),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_OPCODE;
            bit_cnt    <= '0;
            rx_sr      <= '0;
            addr       <= '0;
            rd_ptr     <= '0;
            tx_next    <= '0;
            tx_sr      <= '0;
            wel        <= 1'b0;
            is_read    <= 1'b0;
            pend_valid <= 1'b0;
            pend_data  <= '0;
            prot       <= '0;
        end else begin
            if (tmr_done) wel <= 1'b0;
            if (sr_commit) begin
                prot.wpen <= pend_data[7];
                prot.bp1  <= pend_data[3];
                prot.bp0  <= pend_data[2];
            end

            if (cs_fall || cs_rise) begin
                phase      <= PH_OPCODE;
                bit_cnt    <= '0;
                pend_valid <= 1'b0;
            end else if (cs_low && sck_rise) begin
                rx_sr   <= rx_byte[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    unique case (phase)
                        PH_OPCODE: begin
                            if (busy && op_dec != OP_RDSR) begin
                                phase <= PH_DISCARD;
                            end else begin
                                unique case (op_dec)
                                    OP_WREN: begin wel <= 1'b1; phase <= PH_DISCARD; end
                                    OP_WRDI: begin wel <= 1'b0; phase <= PH_DISCARD; end
                                    OP_RDSR: begin tx_next <= stat_now; phase <= PH_ST_READ; end
                                    OP_WRSR: phase <= wel ? PH_ST_WRITE : PH_DISCARD;
                                    OP_READ: begin is_read <= 1'b1; phase <= PH_ADDR_HI; end
                                    OP_WRITE: begin
                                        is_read <= 1'b0;
                                        phase   <= wel ? PH_ADDR_HI : PH_DISCARD;
                                    end
                                    default: phase <= PH_DISCARD;
                                endcase
                            end
                        end
                        PH_ADDR_HI: begin
                            addr  <= addr_next;
                            phase <= PH_ADDR_LO;
                        end
                        PH_ADDR_LO: begin
                            addr <= addr_next;
                            if (is_read) begin
                                tx_next <= mem_rdata;
                                rd_ptr  <= addr_next + MEM_AW'(1);
                                phase   <= PH_RD_DATA;
                            end else begin
                                phase   <= PH_WR_DATA;
                            end
                        end
                        PH_RD_DATA: begin
                            tx_next <= mem_rdata;
                            rd_ptr  <= rd_ptr + MEM_AW'(1);
                        end
                        PH_WR_DATA, PH_ST_WRITE: begin
                            if (!pend_valid) begin
                                pend_valid <= 1'b1;
                                pend_data  <= rx_byte;
                            end
                        end
                        PH_ST_READ: tx_next <= stat_now;
                        default: ;
                    endcase
                end
            end else if (cs_low && sck_fall) begin
                tx_sr <= (bit_cnt == 3'd0) ? tx_next : {tx_sr[6:0], 1'b0};
            end
        end
    end

    assign miso = (cs_low && (phase == PH_RD_DATA || phase == PH_ST_READ)) ? tx_sr[7] : 1'b0;
endmodule

// File: rtl/spi_eeprom_slave_chk.sv
module spi_eeprom_slave_chk #(
    parameter int unsigned CYCLES = 64
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic miso,
    input logic busy,
    input logic wel,
    input logic mem_we
);
    logic [31:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 32'd1;
        else           busy_run <= '0;
    end

    // R11
    miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

    // R3
    start_needs_wen_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> wel);

    // R7
    wen_cleared_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    // R7
    busy_length_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < CYCLES));

    // R8
    no_wen_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> !$past(busy));

    // R6
    no_write_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !busy);
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk #(.CYCLES(WRITE_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .miso(miso),
    .busy(busy), .wel(wel), .mem_we(mem_we)
);

// File: tb/spi_eeprom_slave_test.sv
module spi_eeprom_slave_test;
    localparam int HALF = 6;
    localparam int WCYC = 2500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic wp_n = 1'b1;
    logic miso;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    spi_eeprom_slave #(.MEM_AW(8), .WRITE_CYCLES(WCYC), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .wp_n(wp_n), .miso(miso)
    );

    // {address, data}
    localparam logic [23:0] VEC [4] = '{24'h0010_5A, 24'h8011_A5, 24'h00FF_3C, 24'h0100_77};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bits(input int n, input logic [7:0] tx, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(8, tx, rx);
    endtask

    task automatic cs_on;
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_off;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] d;
        cs_on; xfer(op, d); cs_off;
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        cs_on; xfer(8'h05, d); xfer(8'h00, s); cs_off;
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        cs_on; xfer(8'h01, d); xfer(v, d); cs_off;
    endtask

    task automatic write_byte(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] d;
        cs_on; xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(v, d); cs_off;
    endtask

    task automatic read2(input logic [15:0] a, output logic [7:0] b0, output logic [7:0] b1);
        logic [7:0] d;
        cs_on; xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
        xfer(8'h00, b0); xfer(8'h00, b1); cs_off;
    endtask

    task automatic wait_ready;
        logic [7:0] s;
        for (int k = 0; k < 60; k++) begin
            rdsr(s);
            if (s[0] == 1'b0) return;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] s, b0, b1, d;
        wait_clk(10);
        rst = 1'b0;
        wait_clk(4);

        // R1 / R11: reset state
        check("R11 miso idle after reset", {7'd0, miso}, 8'h00);
        rdsr(s);
        check("R1 status after reset", s, 8'h00);

        // R2 / R3: enable writes using bit 3 set
        cmd(8'h0E);
        rdsr(s);
        check("R2 R3 wren alias sets WEN", s, 8'h02);

        // R2: invalid high nibble has no effect
        cmd(8'h44);
        rdsr(s);
        check("R2 invalid opcode ignored", s, 8'h02);

        // R4: disable writes with wp_n low
        wp_n = 1'b0;
        cmd(8'h04);
        rdsr(s);
        check("R4 wrdi with wp_n low", s, 8'h00);
        wp_n = 1'b1;

        // Vector table: write, observe busy, wait, read back
        for (int v = 0; v < 4; v++) begin
            cmd(8'h06);
            write_byte(VEC[v][23:8], VEC[v][7:0]);
            rdsr(s);
            check("R7 status 0xFF while busy", s, 8'hFF);
            wait_ready;
            rdsr(s);
            check("R7 WEN cleared after cycle", s, 8'h00);
            read2(VEC[v][23:8], b0, b1);
            check("R5 R6 read back written byte", b0, VEC[v][7:0]);
        end

        // R5: bit 15 ignored, and read wraps across the array end
        read2(16'h0011, b0, b1);
        check("R5 alias of 0x8011", b0, 8'hA5);
        read2(16'h00FF, b0, b1);
        check("R5 stream first byte", b0, 8'h3C);
        check("R5 stream wraps to index 0", b1, 8'h77);

        // R3: write without WEN ignored
        write_byte(16'h0010, 8'h11);
        rdsr(s);
        check("R3 no busy without WEN", s, 8'h00);
        read2(16'h0010, b0, b1);
        check("R3 array unchanged without WEN", b0, 8'h5A);

        // R8: read while busy returns zeros, then completes
        cmd(8'h06);
        write_byte(16'h0020, 8'h99);
        read2(16'h0010, b0, b1);
        check("R8 read blocked while busy", b0, 8'h00);
        cmd(8'h06);
        wait_ready;
        rdsr(s);
        check("R8 wren ignored while busy", s, 8'h00);
        read2(16'h0020, b0, b1);
        check("R6 busy-phase write stored", b0, 8'h99);

        // R6: partial final byte aborts commit
        cmd(8'h06);
        cs_on;
        xfer(8'h02, d); xfer(8'h00, d); xfer(8'h10, d); xfer(8'hEE, d);
        xfer_bits(3, 8'hA0, d);
        cs_off;
        rdsr(s);
        check("R6 partial frame no commit", s, 8'h02);
        read2(16'h0010, b0, b1);
        check("R6 array unchanged after abort", b0, 8'h5A);

        // R9: status write stores bits 7,3,2 only
        wrsr(8'hFC);
        wait_ready;
        rdsr(s);
        check("R9 status layout after wrsr", s, 8'h8C);

        // R10: protected status write with wp_n low
        wp_n = 1'b0;
        cmd(8'h06);
        wrsr(8'h00);
        rdsr(s);
        check("R10 wrsr blocked by wp_n", s, 8'h8E);
        wp_n = 1'b1;
        wrsr(8'h00);
        wait_ready;
        rdsr(s);
        check("R10 wrsr allowed with wp_n high", s, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule